// File: doc/BRIEF.md
# Programmable SCL Clock Generator

This block makes the serial clock waveform for a two-wire (I2C) master out of the system clock. Two 8-bit settings give the lengths of the low and the high phase, each as a count of system clocks. Each phase lasts one clock more than its setting. Settings that are too small for the bus are raised without notice to a floor, which is separate for each phase. The surrounding master logic reads the level and three single-cycle strobes: one for a rising edge, one for a falling edge, and one for the end of a full bit period. It uses them to time its START/STOP handling and its data shifting. Those functions are outside this block.

While the enable is low, the line rests high and the phase timer is cleared. When the enable rises, a low phase begins at once, and after that low and high phases alternate. Each phase takes its setting at the moment it begins. A write to a setting therefore never shortens or stretches the phase that is already running.

Top module: `scl_clkgen`

## Requirements
- R1: With a low setting L of 4 or more, each low phase lasts exactly L+1 system clocks.
- R2: With a high setting H of 2 or more, each high phase lasts exactly H+1 system clocks.
- R3: A high setting of 0 or 1 behaves as 2, so the high phase lasts 3 clocks.
- R4: A low setting of 0 to 3 behaves as 4, so the low phase lasts 5 clocks.
- R5: During reset, and from the first clock after the enable is sampled low, scl_o is 1 and bit_done_o and fall_o are 0; rise_o is 0 as well, except in the single cycle in which scl_o returns to 1.
- R6: The first rising clock edge at which the enable is sampled 1 while idle drives scl_o to 0, starting a low phase.
- R7: rise_o is 1 exactly in the cycles in which scl_o is 1 after being 0 in the previous cycle. This includes the return to 1 on disable.
- R8: fall_o is 1 exactly in the cycles in which scl_o is 0 after being 1 in the previous cycle.
- R9: bit_done_o is 1 for one cycle in the cycle that begins the low phase following each high phase. It is 0 on the first fall after enable.
- R10: Each phase takes its length from the setting present on the clock edge that starts it. A change during a phase only affects later phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| en_i | input | 1 | Run the clock when 1; hold idle high when 0 |
| hi_cfg_i | input | 8 | High-phase setting (clocks minus one, floor 2) |
| lo_cfg_i | input | 8 | Low-phase setting (clocks minus one, floor 4) |
| scl_o | output | 1 | Serial clock level |
| rise_o | output | 1 | One-cycle strobe with each 0-to-1 change of scl_o |
| fall_o | output | 1 | One-cycle strobe with each 1-to-0 change of scl_o |
| bit_done_o | output | 1 | One-cycle strobe when a high phase ends |

## Verification
Every pairing of high and low settings from 0 to 7 is run, and each one measures two complete bit periods. This separates the clamped settings from the unclamped ones and catches off-by-one errors in either phase. The extreme settings of 255 confirm that the full counter range works with no wrap. A run in which settings change halfway through a low phase and halfway through a high phase shows whether a setting is taken at the start of a phase or in the middle of it. Disabling during a low phase exercises the forced return high and its rise strobe.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } phase_e;

    typedef struct packed {
        phase_e phase;
        logic   scl;
        logic   rise;
        logic   fall;
        logic   bit_done;
    } gen_state_t;

endpackage

// File: rtl/scl_cfg_floor.sv
module scl_cfg_floor #(
    parameter int W   = 8,
    parameter int MIN = 2
) (
    input  logic [W-1:0] cfg_i,
    output logic [W-1:0] lim_o
);
    localparam logic [W-1:0] FLOOR = W'(MIN);

    always_comb begin
        lim_o = (cfg_i < FLOOR) ? FLOOR : cfg_i;
    end

    always_comb begin
        a_r3_floor_applied : assert (lim_o >= FLOOR || $isunknown(cfg_i));
    end
endmodule

// File: rtl/scl_phase_timer.sv
module scl_phase_timer #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clear_i,
    input  logic         load_i,
    input  logic [W-1:0] lim_i,
    output logic [W-1:0] cnt_o,
    output logic         done_o
);
    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] lim;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (clear_i) begin
            tmr_d.cnt = '0;
            tmr_d.lim = '0;
        end else if (load_i) begin
            tmr_d.cnt = '0;
            tmr_d.lim = lim_i;
        end else if (tmr_q.cnt != tmr_q.lim) begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) tmr_q <= '0;
        else         tmr_q <= tmr_d;
    end

    assign cnt_o  = tmr_q.cnt;
    assign done_o = (tmr_q.cnt == tmr_q.lim);

    // R10: the phase length is frozen between loads
    a_r10_limit_frozen : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!load_i && !clear_i) |=> $stable(tmr_q.lim));

    // R1/R2: the count never passes the limit
    a_r1_count_bounded : assert property (@(posedge clk_i) disable iff (!rst_ni)
        tmr_q.cnt <= tmr_q.lim);
endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int HI_MIN = 2,
    parameter int LO_MIN = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [CNT_W-1:0] hi_cfg_i,
    input  logic [CNT_W-1:0] lo_cfg_i,
    output logic             scl_o,
    output logic             rise_o,
    output logic             fall_o,
    output logic             bit_done_o
);
    localparam logic [CNT_W-1:0] HI_FLOOR = CNT_W'(HI_MIN);
    localparam logic [CNT_W-1:0] LO_FLOOR = CNT_W'(LO_MIN);

    logic [CNT_W-1:0] hi_lim, lo_lim, tmr_lim, tmr_cnt;
    logic             tmr_done, tmr_load, tmr_clear, sel_hi;

    gen_state_t st_d, st_q;

    scl_cfg_floor #(.W(CNT_W), .MIN(HI_MIN)) u_hi_floor (
        .cfg_i (hi_cfg_i),
        .lim_o (hi_lim)
    );

    scl_cfg_floor #(.W(CNT_W), .MIN(LO_MIN)) u_lo_floor (
        .cfg_i (lo_cfg_i),
        .lim_o (lo_lim)
    );

    assign tmr_lim = sel_hi ? hi_lim : lo_lim;

    scl_phase_timer #(.W(CNT_W)) u_timer (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (tmr_clear),
        .load_i  (tmr_load),
        .lim_i   (tmr_lim),
        .cnt_o   (tmr_cnt),
        .done_o  (tmr_done)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rise     = 1'b0;
        st_d.fall     = 1'b0;
        st_d.bit_done = 1'b0;
        tmr_load      = 1'b0;
        tmr_clear     = 1'b0;
        sel_hi        = 1'b0;
        if (!en_i) begin
            st_d.phase = PH_IDLE;
            st_d.scl   = 1'b1;
            st_d.rise  = !st_q.scl;
            tmr_clear  = 1'b1;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    st_d.phase = PH_LOW;
                    st_d.scl   = 1'b0;
                    st_d.fall  = st_q.scl;
                    tmr_load   = 1'b1;
                end
                PH_LOW: begin
                    if (tmr_done) begin
                        st_d.phase = PH_HIGH;
                        st_d.scl   = 1'b1;
                        st_d.rise  = 1'b1;
                        tmr_load   = 1'b1;
                        sel_hi     = 1'b1;
                    end
                end
                PH_HIGH: begin
                    if (tmr_done) begin
                        st_d.phase    = PH_LOW;
                        st_d.scl      = 1'b0;
                        st_d.fall     = 1'b1;
                        st_d.bit_done = 1'b1;
                        tmr_load      = 1'b1;
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.scl   = 1'b1;
                    tmr_clear  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.phase    <= PH_IDLE;
            st_q.scl      <= 1'b1;
            st_q.rise     <= 1'b0;
            st_q.fall     <= 1'b0;
            st_q.bit_done <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign scl_o      = st_q.scl;
    assign rise_o     = st_q.rise;
    assign fall_o     = st_q.fall;
    assign bit_done_o = st_q.bit_done;

    // R5: a clock with the enable low leaves the line high
    a_r5_idle_high : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(!en_i) |-> (scl_o && !fall_o && !bit_done_o));

    // R7: rise strobe marks a real 0-to-1 change
    a_r7_rise_edge : assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |-> (scl_o && !$past(scl_o)));

    // R8: fall strobe marks a real 1-to-0 change
    a_r8_fall_edge : assert property (@(posedge clk_i) disable iff (!rst_ni)
        fall_o |-> (!scl_o && $past(scl_o)));

    // R9: bit strobe only comes with a fall
    a_r9_bit_on_fall : assert property (@(posedge clk_i) disable iff (!rst_ni)
        bit_done_o |-> fall_o);

    // R7/R8: never both edges at once
    a_r8_one_edge : assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({rise_o, fall_o}));

    // R3: a high phase never ends before the floor count
    a_r3_high_floor : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_HIGH && tmr_done) |-> (tmr_cnt >= HI_FLOOR));

    // R4: a low phase never ends before the floor count
    a_r4_low_floor : assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.phase == PH_LOW && tmr_done) |-> (tmr_cnt >= LO_FLOOR));
endmodule

// File: tb/scl_clkgen_tb_top.sv
module scl_clkgen_tb_top;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic       en = 1'b0;
    logic [7:0] hi_cfg = 8'd0;
    logic [7:0] lo_cfg = 8'd0;
    logic       scl_o, rise_o, fall_o, bit_done_o;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    scl_clkgen dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_ni),
        .en_i       (en),
        .hi_cfg_i   (hi_cfg),
        .lo_cfg_i   (lo_cfg),
        .scl_o      (scl_o),
        .rise_o     (rise_o),
        .fall_o     (fall_o),
        .bit_done_o (bit_done_o)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // Count cycles until scl_o changes; checks strobes stay quiet meanwhile.
    task automatic phase_len(input logic lvl, output int len);
        len = 0;
        do begin
            step();
            len++;
            if (scl_o == lvl)
                chk(!rise_o && !fall_o && !bit_done_o, "R7 R8 quiet strobes",
                    int'({rise_o, fall_o, bit_done_o}), 0);
        end while (scl_o == lvl && len < 600);
    endtask

    function automatic int exp_lo(input int lo);
        return (lo < 4 ? 4 : lo) + 1;
    endfunction

    function automatic int exp_hi(input int hi);
        return (hi < 2 ? 2 : hi) + 1;
    endfunction

    task automatic run_cfg(input int hi, input int lo);
        int len;
        string tl, th;
        tl = (lo < 4) ? "R4 low clamp" : "R1 low length";
        th = (hi < 2) ? "R3 high clamp" : "R2 high length";
        en = 1'b0;
        step();
        step();
        hi_cfg = 8'(hi);
        lo_cfg = 8'(lo);
        en = 1'b1;
        step();
        chk(scl_o == 1'b0 && fall_o == 1'b1, "R6 first low", int'({scl_o, fall_o}), 1);
        chk(bit_done_o == 1'b0, "R9 no bit on first fall", int'(bit_done_o), 0);
        for (int p = 0; p < 2; p++) begin
            phase_len(1'b0, len);
            chk(len == exp_lo(lo), tl, len, exp_lo(lo));
            chk(rise_o == 1'b1 && fall_o == 1'b0, "R7 rise strobe", int'({rise_o, fall_o}), 2);
            phase_len(1'b1, len);
            chk(len == exp_hi(hi), th, len, exp_hi(hi));
            chk(fall_o && bit_done_o && !rise_o, "R9 bit strobe",
                int'({rise_o, fall_o, bit_done_o}), 3);
        end
    endtask

    initial begin
        int len;
        repeat (3) step();
        chk(scl_o && !rise_o && !fall_o && !bit_done_o, "R5 reset state",
            int'({scl_o, rise_o, fall_o, bit_done_o}), 8);
        rst_ni = 1'b1;
        repeat (4) step();
        chk(scl_o && !rise_o && !fall_o && !bit_done_o, "R5 idle disabled",
            int'({scl_o, rise_o, fall_o, bit_done_o}), 8);

        for (int h = 0; h < 8; h++)
            for (int l = 0; l < 8; l++)
                run_cfg(h, l);
        run_cfg(255, 255);
        run_cfg(255, 4);
        run_cfg(2, 255);

        // R10: changes during a phase only affect later phases
        en = 1'b0;
        step();
        hi_cfg = 8'd3;
        lo_cfg = 8'd10;
        en = 1'b1;
        step();
        chk(fall_o == 1'b1, "R6 start", int'(fall_o), 1);
        step();
        step();
        lo_cfg = 8'd6;
        hi_cfg = 8'd8;
        phase_len(1'b0, len);
        len = len + 2;
        chk(len == 11, "R10 low kept", len, 11);
        step();
        hi_cfg = 8'd5;
        phase_len(1'b1, len);
        len = len + 1;
        chk(len == 9, "R10 high from start", len, 9);
        phase_len(1'b0, len);
        chk(len == 7, "R10 new low", len, 7);
        phase_len(1'b1, len);
        chk(len == 6, "R10 new high", len, 6);

        // R5/R7: disable in the middle of a low phase
        step();
        step();
        chk(scl_o == 1'b0, "R5 in low before disable", int'(scl_o), 0);
        en = 1'b0;
        step();
        chk(scl_o && rise_o && !fall_o, "R7 rise on disable",
            int'({scl_o, rise_o, fall_o}), 6);
        for (int i = 0; i < 20; i++) begin
            step();
            chk(scl_o && !rise_o && !fall_o && !bit_done_o, "R5 held high",
                int'({scl_o, rise_o, fall_o, bit_done_o}), 8);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule